// File: doc/BRIEF.md
# Shared USB / PS2 Pin Pair Controller

This block lets two pins be used either by a USB serial engine or by a PS2 port that firmware drives one bit at a time. A two-bit mode field selects the owner. In PS2 mode the minus line carries PS2 data and the plus line carries PS2 clock. Each line behaves as an open-drain output: when its output latch holds 0 the pad pulls low, and when it holds 1 the pad is released to an external pull-up. In USB mode the pads connect directly to the engine's drive, enable and receive signals. In any other mode the pads float and the engine is cut off.

Firmware uses a small register port. A write with `reg_sel` low updates the mode register, and a write with `reg_sel` high updates the control register. Reads are combinational from the selected register. Pad inputs pass through a two-flop synchroniser before they reach the readable sample bits, and a sample bit reads as the line level only while the matching output latch holds 1.

Top module: `ps2usb_pinmux`

## Requirements
- R1: After reset, the mode register reads 0x00 and the control register reads 0xC0: both output latches are 1 and both sample bits are 0.
- R2: The mode field is mode register bits {5,4} = {usb_sel, ps2_sel}. The value 01 selects PS2 mode, 10 selects USB mode, and 00 or 11 selects off.
- R3: In PS2 mode, pad_dm_oe is the inverse of the data latch (control bit 6), pad_dp_oe is the inverse of the clock latch (control bit 7), and both pad outputs are 0.
- R4: In PS2 mode, control bit 4 reads the synchronised minus-pad level ANDed with the data latch, and control bit 5 reads the synchronised plus-pad level ANDed with the clock latch.
- R5: A pad input change shows in the control read after the second rising clock edge, and not after the first.
- R6: In USB mode, both pad enables equal usb_drv_oe, the pad outputs equal usb_dm_drv and usb_dp_drv, and usb_dm_rcv and usb_dp_rcv equal the pad inputs without delay.
- R7: In USB mode, writes to the output latches do not affect the pads, and both sample bits read 0.
- R8: In off mode, both pad enables are 0, both pad outputs are 0, both engine receive outputs are 0, and both sample bits read 0. In PS2 mode the engine receive outputs are also 0.
- R9: A mode write stores only bits 5:4, and all other mode bits read 0. A control write stores only bits 7:6. Control bits 3:0 read 0, and writes to control bits 5:4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 selects the mode register, 1 selects the control register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data from the selected register (combinational) |
| pad_dm_in | input | 1 | Minus pad input level |
| pad_dp_in | input | 1 | Plus pad input level |
| pad_dm_out | output | 1 | Minus pad output value |
| pad_dp_out | output | 1 | Plus pad output value |
| pad_dm_oe | output | 1 | Minus pad output enable |
| pad_dp_oe | output | 1 | Plus pad output enable |
| usb_dm_drv | input | 1 | Engine drive value for the minus line |
| usb_dp_drv | input | 1 | Engine drive value for the plus line |
| usb_drv_oe | input | 1 | Engine drive enable |
| usb_dm_rcv | output | 1 | Minus line level returned to the engine |
| usb_dp_rcv | output | 1 | Plus line level returned to the engine |

## Verification
Register writes take effect at the next rising edge, and the pad enables and outputs follow combinationally from the registers. The bench therefore checks pads and read-back one falling edge after a write. Sample bits trail the pads by two rising edges. The bench waits three falling edges after a pad change for table vectors, and for the latency test it checks the read at one edge (old value expected) and again at two edges (new value expected). The USB receive path has no register, so it is checked in the same half cycle that the pads are driven.

// File: rtl/ps2usb_pkg.sv
package ps2usb_pkg;

    localparam int REG_W        = 8;
    localparam int MODE_PS2_BIT = 4;
    localparam int MODE_USB_BIT = 5;
    localparam int CTL_DAT_IN   = 4;
    localparam int CTL_CLK_IN   = 5;
    localparam int CTL_DAT_OUT  = 6;
    localparam int CTL_CLK_OUT  = 7;
    localparam int PAIR_W       = 2;

    typedef enum logic [1:0] {
        PM_OFF = 2'd0,
        PM_PS2 = 2'd1,
        PM_USB = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic usb_sel;
        logic ps2_sel;
    } mode_reg_t;

    typedef struct packed {
        logic clk_lat;
        logic dat_lat;
    } latch_t;

    typedef struct packed {
        logic dm;
        logic dp;
    } pin_pair_t;

    function automatic pin_mode_e decode_mode(mode_reg_t m);
        pin_mode_e r;
        case ({m.usb_sel, m.ps2_sel})
            2'b01:   r = PM_PS2;
            2'b10:   r = PM_USB;
            default: r = PM_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ps2usb_sync.sv
module ps2usb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q[s] <= '0;
                else     q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q[s] <= '0;
                else     q[s] <= q[s-1];
            end
        end
    end

    assign dout = q[STAGES-1];

    // warm-up counter: the delay check starts only once the history is valid
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    if (STAGES == 2) begin : g_chk
        AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
            (warm == 2'd2) |-> (dout == $past(din, 2))); // R5
    end

endmodule

// File: rtl/ps2usb_regs.sv
module ps2usb_regs
    import ps2usb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  pin_pair_t        samp,
    output pin_mode_e        mode,
    output latch_t           latch,
    output logic [REG_W-1:0] rd_data
);

    mode_reg_t mode_q;
    latch_t    lat_q;
    logic      rd_dat_samp;
    logic      rd_clk_samp;
    logic      unused_wr;

    assign unused_wr = ^wr_data[3:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            lat_q  <= '1;
        end else if (wr_en) begin
            if (!reg_sel) begin
                mode_q.usb_sel <= wr_data[MODE_USB_BIT];
                mode_q.ps2_sel <= wr_data[MODE_PS2_BIT];
            end else begin
                lat_q.clk_lat <= wr_data[CTL_CLK_OUT];
                lat_q.dat_lat <= wr_data[CTL_DAT_OUT];
            end
        end
    end

    assign mode  = decode_mode(mode_q);
    assign latch = lat_q;

    // open-drain read-back: a line released by its own latch is visible
    assign rd_dat_samp = (mode == PM_PS2) && lat_q.dat_lat && samp.dm;
    assign rd_clk_samp = (mode == PM_PS2) && lat_q.clk_lat && samp.dp;

    always_comb begin
        rd_data = '0;
        if (!reg_sel) begin
            rd_data[MODE_USB_BIT] = mode_q.usb_sel;
            rd_data[MODE_PS2_BIT] = mode_q.ps2_sel;
        end else begin
            rd_data[CTL_CLK_OUT] = lat_q.clk_lat;
            rd_data[CTL_DAT_OUT] = lat_q.dat_lat;
            rd_data[CTL_CLK_IN]  = rd_clk_samp;
            rd_data[CTL_DAT_IN]  = rd_dat_samp;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == '0 && lat_q == 2'b11)); // R1
    AST_SAMPLE_GATED: assert property (@(posedge clk) disable iff (rst)
        (!lat_q.dat_lat || mode != PM_PS2) |-> !rd_dat_samp); // R4
    AST_MODE_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> (rd_data[3:0] == '0 && rd_data[7:6] == '0)); // R9

endmodule

// File: rtl/ps2usb_padmux.sv
module ps2usb_padmux
    import ps2usb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_mode_e mode,
    input  latch_t    latch,
    input  pin_pair_t pad_in,
    input  pin_pair_t usb_drv,
    input  logic      usb_oe,
    output pin_pair_t pad_out,
    output pin_pair_t pad_oe,
    output pin_pair_t usb_rcv
);

    always_comb begin
        pad_out = '0;
        pad_oe  = '0;
        usb_rcv = '0;
        case (mode)
            PM_PS2: begin
                pad_oe.dm = ~latch.dat_lat;
                pad_oe.dp = ~latch.clk_lat;
            end
            PM_USB: begin
                pad_out = usb_drv;
                pad_oe  = {usb_oe, usb_oe};
                usb_rcv = pad_in;
            end
            default: ;
        endcase
    end

    AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_OFF) |-> (pad_oe == '0 && usb_rcv == '0)); // R8
    AST_PS2_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_PS2 && latch.dat_lat) |-> !pad_oe.dm); // R3
    AST_PS2_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_PS2) |-> (pad_out == '0)); // R3
    AST_USB_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_USB) |-> (pad_oe.dm == usb_oe && pad_oe.dp == usb_oe)); // R6

endmodule

// File: rtl/ps2usb_pinmux.sv
module ps2usb_pinmux
    import ps2usb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       pad_dm_in,
    input  logic       pad_dp_in,
    output logic       pad_dm_out,
    output logic       pad_dp_out,
    output logic       pad_dm_oe,
    output logic       pad_dp_oe,
    input  logic       usb_dm_drv,
    input  logic       usb_dp_drv,
    input  logic       usb_drv_oe,
    output logic       usb_dm_rcv,
    output logic       usb_dp_rcv
);

    pin_mode_e mode;
    latch_t    latch;
    pin_pair_t pad_in, samp, pad_out, pad_oe, usb_drv, usb_rcv;

    assign pad_in  = '{dm: pad_dm_in,  dp: pad_dp_in};
    assign usb_drv = '{dm: usb_dm_drv, dp: usb_dp_drv};

    ps2usb_sync #(.WIDTH(PAIR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (samp)
    );

    ps2usb_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .samp    (samp),
        .mode    (mode),
        .latch   (latch),
        .rd_data (rd_data)
    );

    ps2usb_padmux u_padmux (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .latch   (latch),
        .pad_in  (pad_in),
        .usb_drv (usb_drv),
        .usb_oe  (usb_drv_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .usb_rcv (usb_rcv)
    );

    assign pad_dm_out = pad_out.dm;
    assign pad_dp_out = pad_out.dp;
    assign pad_dm_oe  = pad_oe.dm;
    assign pad_dp_oe  = pad_oe.dp;
    assign usb_dm_rcv = usb_rcv.dm;
    assign usb_dp_rcv = usb_rcv.dp;

endmodule

// File: tb/ps2usb_pinmux_tb.sv
module ps2usb_pinmux_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_sel = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic pad_dm_in = 1'b1, pad_dp_in = 1'b1;
    logic pad_dm_out, pad_dp_out, pad_dm_oe, pad_dp_oe;
    logic usb_dm_drv = 1'b0, usb_dp_drv = 1'b0, usb_drv_oe = 1'b0;
    logic usb_dm_rcv, usb_dp_rcv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ps2usb_pinmux u_dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .pad_dm_in(pad_dm_in), .pad_dp_in(pad_dp_in),
        .pad_dm_out(pad_dm_out), .pad_dp_out(pad_dp_out),
        .pad_dm_oe(pad_dm_oe), .pad_dp_oe(pad_dp_oe),
        .usb_dm_drv(usb_dm_drv), .usb_dp_drv(usb_dp_drv), .usb_drv_oe(usb_drv_oe),
        .usb_dm_rcv(usb_dm_rcv), .usb_dp_rcv(usb_dp_rcv)
    );

    // [16:15] mode {usb,ps2} [14:13] latch {clk,dat} [12] dm_in [11] dp_in
    // [10] usb_dm [9] usb_dp [8] usb_oe | expected: [7] dm_oe [6] dp_oe
    // [5] dm_out [4] dp_out [3] dat sample [2] clk sample [1] rcv dm [0] rcv dp
    localparam int NV = 9;
    localparam logic [16:0] VEC [NV] = '{
        17'b01_11_1_1_0_0_0_0_0_0_0_1_1_0_0,
        17'b01_11_0_1_0_0_0_0_0_0_0_0_1_0_0,
        17'b01_01_1_1_0_0_0_0_1_0_0_1_0_0_0,
        17'b01_10_1_0_0_0_0_1_0_0_0_0_0_0_0,
        17'b01_00_1_1_0_0_0_1_1_0_0_0_0_0_0,
        17'b10_11_0_1_1_0_1_1_1_1_0_0_0_0_1,
        17'b10_00_1_1_0_1_0_0_0_0_1_0_0_1_1,
        17'b00_00_1_1_1_1_1_0_0_0_0_0_0_0_0,
        17'b11_11_1_1_1_1_1_0_0_0_0_0_0_0_0
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_sel = sel;
        #1;
        d = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd(1'b0, r); chk("R1 mode reset", r, 8'h00);
        rd(1'b1, r); chk("R1 ctrl reset", r, 8'hC0);
        chk("R8 pads idle after reset", {6'b0, pad_dm_oe, pad_dp_oe}, 8'h00);

        // vector table: R2 mode decode through R3/R4/R6/R8 behaviour
        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            tag = (v[16:15] == 2'b01) ? "R3" : (v[16:15] == 2'b10) ? "R6" : "R8";
            wr(1'b0, {2'b00, v[16:15], 4'h0});
            wr(1'b1, {v[14:13], 6'h00});
            pad_dm_in = v[12]; pad_dp_in = v[11];
            usb_dm_drv = v[10]; usb_dp_drv = v[9]; usb_drv_oe = v[8];
            repeat (3) @(negedge clk);
            chk({tag, " pad enables"}, {6'b0, pad_dm_oe, pad_dp_oe}, {6'b0, v[7:6]});
            chk({tag, " pad outputs"}, {6'b0, pad_dm_out, pad_dp_out}, {6'b0, v[5:4]});
            chk({tag, " engine receive"}, {6'b0, usb_dm_rcv, usb_dp_rcv}, {6'b0, v[1:0]});
            rd(1'b1, r);
            chk("R4 ctrl read", r, {v[14:13], v[2], v[3], 4'h0});
        end

        // R2: both selects set means off, even with latches low
        wr(1'b0, 8'h30);
        wr(1'b1, 8'h00);
        chk("R2 both selects off", {6'b0, pad_dm_oe, pad_dp_oe}, 8'h00);

        // R9: spare bits
        wr(1'b0, 8'hFF);
        rd(1'b0, r); chk("R9 mode spare bits", r, 8'h30);
        wr(1'b1, 8'h3F);
        rd(1'b1, r); chk("R9 ctrl spare bits", r, 8'h00);

        // R5: two-edge synchroniser latency
        wr(1'b0, 8'h10);
        wr(1'b1, 8'hC0);
        pad_dm_in = 1'b1; pad_dp_in = 1'b1;
        repeat (3) @(negedge clk);
        rd(1'b1, r); chk("R5 settled high", r, 8'hF0);
        pad_dm_in = 1'b0;
        @(negedge clk);
        rd(1'b1, r); chk("R5 one edge still old", r, 8'hF0);
        @(negedge clk);
        rd(1'b1, r); chk("R5 two edges new", r, 8'hE0);

        // R7: latch writes ignored by pads in USB mode
        wr(1'b0, 8'h20);
        usb_drv_oe = 1'b1; usb_dm_drv = 1'b1; usb_dp_drv = 1'b1;
        pad_dm_in = 1'b1; pad_dp_in = 1'b1;
        wr(1'b1, 8'h00);
        chk("R7 latches low pads", {4'b0, pad_dm_oe, pad_dp_oe, pad_dm_out, pad_dp_out}, 8'h0F);
        wr(1'b1, 8'hC0);
        chk("R7 latches high pads", {4'b0, pad_dm_oe, pad_dp_oe, pad_dm_out, pad_dp_out}, 8'h0F);
        repeat (3) @(negedge clk);
        rd(1'b1, r); chk("R7 samples read zero", r, 8'hC0);

        // R6: receive path is immediate
        pad_dm_in = 1'b0;
        #1;
        chk("R6 receive no delay", {6'b0, usb_dm_rcv, usb_dp_rcv}, 8'h01);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule